// File: doc/BRIEF.md
# Double-Data-Rate Late-Write Synchronous SRAM

This block models a synchronous static RAM whose data pins run at twice the command rate. A command is taken once per memory clock cycle, at the rising edge. Each access moves one full word of `2*W` bits as two half-width beats. The low half travels first and the high half second. The pins form a half-width bidirectional bus, split into an input port, an output port and an output enable. A chip-level pad ties them together.

Both edges of the memory clock are modelled with a single 2x clock, `clk2x`. An internal phase bit alternates between the rising slot and the falling slot after reset and is brought out as `ck`. Reads are pipelined: the word is fetched at the command edge, its low half is driven after the next rising edge, and its high half after the falling edge that follows. Writes use late-write timing, so the data beats arrive one cycle after the command. An advance strobe continues the last access at the next address, and a read in the cycle right after a write to the same address returns the new word.

Top module: `ddr_sram`

## Requirements
- R1: A command is loaded at a rising slot when `adv_n` is 0. It is a read when `ce1_n`=0, `ce2`=1, `ce3_n`=0 and `we_n`=1. It is a write under the same enables with `we_n`=0. With any one enable inactive it is a deselect, which neither reads nor writes, whatever the value of `we_n`.
- R2: For a read loaded at rising slot k, `dq_out` carries bits W-1:0 of the word after rising slot k+1 and bits 2W-1:W after the falling slot that follows, with `dq_oe`=1 in both halves. `ck` reads 1 after every rising slot and 0 after every falling slot.
- R3: For a write loaded at rising slot k, `dq_in` is sampled at rising slot k+1 as bits W-1:0 and at the following falling slot as bits 2W-1:W. The assembled word is stored at the write's address.
- R4: A read loaded in the cycle right after a write to the same address returns the word just written. A read of a different address in that cycle returns that address's stored content.
- R5: In the cycle after a deselect, a write, or an advance with no burst open, `dq_oe` is 0 in both halves.
- R6: `cq` is 1 during the low-half beat, 0 during the high-half beat, and 0 whenever `dq_oe` is 0.
- R7: At a rising slot with `adv_n`=1, the last loaded access type continues at the previous word address plus one, with 2^AW-1 wrapping to 0. The enables and `we_n` are ignored in that cycle. If the last load was a deselect, the advance is a deselect too.
- R8: `dq_oe` is 0 in both halves of every cycle in which write data is being sampled. Reads and writes in consecutive cycles are accepted with no idle cycle between them.
- R9: While `rst_n` is 0, `dq_oe`, `cq`, `ck` and `dq_out` are 0 and no burst is open, so an advance right after reset does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the memory clock rate; alternate edges are the rising and falling slots |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address of a loaded command |
| adv_n | input | 1 | 0 loads a new command, 1 continues the open burst |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| dq_in | input | W | Write data beat from the pad |
| dq_out | output | W | Read data beat to the pad |
| dq_oe | output | 1 | Pad drive enable for `dq_out` |
| cq | output | 1 | Echo clock, high in the first beat of a read |
| ck | output | 1 | Memory clock level reconstructed from the phase bit |

## Verification
If the phase bit or the read pipeline flag goes wrong, the next cycle shows a beat in the wrong half, a missing `cq` pulse, or `dq_oe` raised during a write-data cycle. A wrong late-write address or data register stays hidden until that address is read again. The bench therefore re-reads every written word. It also reads in the cycle right after each write, so that a stale or wrongly taken bypass shows within two cycles. Errors in advance or deselect decoding appear as data from the wrong address, or as a word later found changed by a command that should have been ignored.

// File: rtl/ddr_sram_pkg.sv
package ddr_sram_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // all three enables must be in their active state
  function automatic logic chip_on(input logic e1_n, input logic e2, input logic e3_n);
    return !e1_n && e2 && !e3_n;
  endfunction

  // access type of a freshly loaded command
  function automatic acc_e load_kind(input logic sel, input logic wr_n);
    if (!sel) return ACC_NONE;
    return wr_n ? ACC_READ : ACC_WRITE;
  endfunction

endpackage

// File: rtl/ddr_sram_ctl.sv
module ddr_sram_ctl
  import ddr_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          adv_n,
  input  logic          sel,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output logic          rd_go,
  output logic          wr_go,
  output logic [AW-1:0] eff_addr,
  output logic          rd_pend,
  output logic          byp_hit,
  output logic          wr_pend,
  output logic [AW-1:0] wr_addr
);

  // linear burst step with wrap at the top of the array
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  acc_e          last_t;
  logic [AW-1:0] last_a;
  acc_e          now_t;

  always_comb begin
    if (adv_n) begin
      now_t    = last_t;
      eff_addr = step_addr(last_a);
    end else begin
      now_t    = load_kind(sel, we_n);
      eff_addr = addr;
    end
    rd_go = (now_t == ACC_READ);
    wr_go = (now_t == ACC_WRITE);
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      last_t  <= ACC_NONE;
      last_a  <= '0;
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
      wr_addr <= '0;
      byp_hit <= 1'b0;
    end else if (rise) begin
      last_t  <= now_t;
      if (now_t != ACC_NONE) last_a <= eff_addr;
      rd_pend <= rd_go;
      wr_pend <= wr_go;
      if (wr_go) wr_addr <= eff_addr;
      // the previous cycle's write is still collecting data: forward it
      byp_hit <= rd_go && wr_pend && (wr_addr == eff_addr);
    end
  end

endmodule

// File: rtl/ddr_sram_wcap.sv
module ddr_sram_wcap #(
  parameter int AW = 8,
  parameter int W  = 18
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          wr_pend,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  dq_in,
  output logic          dat_v,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [2*W-1:0] commit_word,
  output logic [2*W-1:0] byp_word
);

  logic [W-1:0] lo_q, hi_q;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      dat_v       <= 1'b0;
      lo_q        <= '0;
      hi_q        <= '0;
      commit_addr <= '0;
    end else if (rise) begin
      dat_v <= wr_pend;
      if (wr_pend) begin
        lo_q        <= dq_in;
        commit_addr <= wr_addr;
      end
    end else if (fall && dat_v) begin
      hi_q <= dq_in;
    end
  end

  assign commit      = fall && dat_v;
  assign commit_word = {dq_in, lo_q};
  assign byp_word    = {hi_q, lo_q};

endmodule

// File: rtl/ddr_sram_array.sv
module ddr_sram_array #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic          clk2x,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk2x) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ddr_sram_outmux.sv
module ddr_sram_outmux #(
  parameter int W = 18
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          rd_pend,
  input  logic          byp_hit,
  input  logic [2*W-1:0] rd_word,
  input  logic [2*W-1:0] byp_word,
  output logic [W-1:0]  dq_out,
  output logic          dq_oe,
  output logic          cq
);

  logic [2*W-1:0] word;
  logic [W-1:0]   beat1_q;

  assign word = byp_hit ? byp_word : rd_word;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      dq_out  <= '0;
      dq_oe   <= 1'b0;
      cq      <= 1'b0;
      beat1_q <= '0;
    end else if (rise) begin
      dq_oe <= rd_pend;
      cq    <= rd_pend;
      if (rd_pend) begin
        dq_out  <= word[W-1:0];
        beat1_q <= word[2*W-1:W];
      end else begin
        dq_out  <= '0;
      end
    end else if (fall) begin
      cq <= 1'b0;
      if (dq_oe) dq_out <= beat1_q;
    end
  end

endmodule

// File: rtl/ddr_sram.sv
module ddr_sram
  import ddr_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int W  = 18
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          adv_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          we_n,
  input  logic [W-1:0]  dq_in,
  output logic [W-1:0]  dq_out,
  output logic          dq_oe,
  output logic          cq,
  output logic          ck
);

  localparam int DW = 2 * W;

  logic          phase;
  logic          rise, fall;
  logic          sel_w;
  logic          rd_go, wr_go;
  logic [AW-1:0] eff_addr;
  logic          rd_pend, byp_hit, wr_pend;
  logic [AW-1:0] wr_addr;
  logic          dat_v, commit;
  logic [AW-1:0] commit_addr;
  logic [DW-1:0] commit_word, byp_word, rd_word;

  // phase 0: the next clk2x edge is a memory-clock rising edge
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  assign rise  = !phase;
  assign fall  = phase;
  assign ck    = phase;
  assign sel_w = chip_on(ce1_n, ce2, ce3_n);

  ddr_sram_ctl #(.AW(AW)) u_ctl (
    .clk2x(clk2x), .rst_n(rst_n), .rise(rise), .adv_n(adv_n), .sel(sel_w),
    .we_n(we_n), .addr(addr), .rd_go(rd_go), .wr_go(wr_go), .eff_addr(eff_addr),
    .rd_pend(rd_pend), .byp_hit(byp_hit), .wr_pend(wr_pend), .wr_addr(wr_addr)
  );

  ddr_sram_wcap #(.AW(AW), .W(W)) u_wcap (
    .clk2x(clk2x), .rst_n(rst_n), .rise(rise), .fall(fall), .wr_pend(wr_pend),
    .wr_addr(wr_addr), .dq_in(dq_in), .dat_v(dat_v), .commit(commit),
    .commit_addr(commit_addr), .commit_word(commit_word), .byp_word(byp_word)
  );

  ddr_sram_array #(.AW(AW), .DW(DW)) u_array (
    .clk2x(clk2x), .we(commit), .waddr(commit_addr), .wdata(commit_word),
    .re(rise && rd_go), .raddr(eff_addr), .rdata(rd_word)
  );

  ddr_sram_outmux #(.W(W)) u_out (
    .clk2x(clk2x), .rst_n(rst_n), .rise(rise), .fall(fall), .rd_pend(rd_pend),
    .byp_hit(byp_hit), .rd_word(rd_word), .byp_word(byp_word),
    .dq_out(dq_out), .dq_oe(dq_oe), .cq(cq)
  );

endmodule

// File: rtl/ddr_sram_chk.sv
module ddr_sram_chk (
  input logic clk2x,
  input logic rst_n,
  input logic rise,
  input logic adv_n,
  input logic sel,
  input logic rd_go,
  input logic wr_go,
  input logic dat_v,
  input logic dq_oe,
  input logic cq
);

  // R1
  enable_gate_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (rise && !adv_n && !sel) |-> !(rd_go || wr_go));

  // R2
  read_beat_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (rise && rd_go) |=> ##2 (dq_oe && cq));

  // R3
  wr_slot_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (rise && wr_go) |=> ##2 dat_v);

  // R5
  idle_quiet_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (rise && !rd_go) |=> ##2 !dq_oe);

  // R6
  echo_pair_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    cq |=> (!cq && dq_oe));

  // R6
  echo_idle_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    cq |-> dq_oe);

  // R8
  no_contend_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    dat_v |-> !dq_oe);

endmodule

bind ddr_sram ddr_sram_chk u_chk (
  .clk2x(clk2x), .rst_n(rst_n), .rise(rise), .adv_n(adv_n), .sel(sel_w),
  .rd_go(rd_go), .wr_go(wr_go), .dat_v(dat_v), .dq_oe(dq_oe), .cq(cq)
);

// File: tb/ddr_sram_bench.sv
module ddr_sram_bench;

  localparam int AW = 8;
  localparam int W  = 18;
  localparam int NV = 30;

  // row: {kind[2:0], addr[7:0], expected dq_oe in the cycle of this row}
  // kind: 0 deselect(ce1_n), 1 read, 2 write, 3 advance, 4 ce2 off + we_n low, 5 ce3_n off + we_n low
  localparam logic [11:0] VEC [NV] = '{
    {3'd2, 8'h10, 1'b0}, {3'd2, 8'h11, 1'b0}, {3'd1, 8'h10, 1'b0}, {3'd1, 8'h11, 1'b1},
    {3'd0, 8'h00, 1'b1}, {3'd1, 8'h10, 1'b0}, {3'd2, 8'h20, 1'b1}, {3'd1, 8'h20, 1'b0},
    {3'd2, 8'h30, 1'b1}, {3'd3, 8'h00, 1'b0}, {3'd1, 8'h30, 1'b0}, {3'd3, 8'h00, 1'b1},
    {3'd4, 8'h10, 1'b1}, {3'd1, 8'h10, 1'b0}, {3'd0, 8'h00, 1'b1}, {3'd3, 8'h00, 1'b0},
    {3'd2, 8'hFF, 1'b0}, {3'd3, 8'h00, 1'b0}, {3'd1, 8'hFF, 1'b0}, {3'd3, 8'h00, 1'b1},
    {3'd0, 8'h00, 1'b1}, {3'd0, 8'h00, 1'b0}, {3'd2, 8'h51, 1'b0}, {3'd2, 8'h50, 1'b0},
    {3'd1, 8'h51, 1'b0}, {3'd0, 8'h00, 1'b1}, {3'd5, 8'h50, 1'b0}, {3'd1, 8'h50, 1'b0},
    {3'd0, 8'h00, 1'b1}, {3'd0, 8'h00, 1'b0}
  };

  logic          clk2x = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          adv_n, ce1_n, ce2, ce3_n, we_n;
  logic [W-1:0]  dq_in;
  logic [W-1:0]  dq_out;
  logic          dq_oe, cq, ck;

  always #5 clk2x = ~clk2x;

  ddr_sram #(.AW(AW), .W(W)) u_ddr_sram (
    .clk2x(clk2x), .rst_n(rst_n), .addr(addr), .adv_n(adv_n), .ce1_n(ce1_n),
    .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .cq(cq), .ck(ck)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [2*W-1:0] mm [1 << AW];

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] dlo(input int j);
    return W'(j * 37 + 5);
  endfunction

  function automatic logic [W-1:0] dhi(input int j);
    return W'(j * 91 + 3) ^ 18'h2AAAA;
  endfunction

  task automatic set_cmd(input int kind, input logic [AW-1:0] a, input int j);
    addr = a; adv_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; we_n = 1'b1;
    case (kind)
      0: ce1_n = 1'b1;
      2: we_n  = 1'b0;
      3: begin adv_n = 1'b1; ce1_n = 1'b1; we_n = j[0]; addr = 8'hA5; end
      4: begin ce2 = 1'b0; we_n = 1'b0; end
      5: begin ce3_n = 1'b1; we_n = 1'b0; end
      default: ;
    endcase
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int last_t, prev_t, prev_kind;
    logic [AW-1:0] last_a, prev_a, ea;
    bit prev_byp;
    rst_n = 1'b0; dq_in = '0;
    set_cmd(0, '0, 0);
    repeat (3) @(negedge clk2x);
    // R9 reset state
    chk("R9", "dq_oe", W'(dq_oe), W'(0));
    chk("R9", "cq", W'(cq), W'(0));
    chk("R9", "ck", W'(ck), W'(0));
    chk("R9", "dq_out", dq_out, '0);
    rst_n = 1'b1;

    last_t = 0; last_a = '0; prev_t = 0; prev_a = '0; prev_byp = 1'b0; prev_kind = 0;
    for (int j = 0; j < NV; j++) begin
      int kind, t;
      logic eoe;
      logic [2*W-1:0] ew;
      bit cur_byp;
      string dtag, otag;
      kind = int'(VEC[j][11:9]);
      eoe  = VEC[j][0];
      // effective access of this row (R1, R7)
      if (kind == 3) begin
        t  = last_t;
        ea = last_a + 8'd1;
      end else begin
        t  = (kind == 1) ? 1 : (kind == 2) ? 2 : 0;
        ea = VEC[j][8:1];
      end
      if (t != 0) last_a = ea;
      last_t  = t;
      cur_byp = (t == 1) && (prev_t == 2) && (prev_a == ea);
      ew = (prev_t == 1) ? mm[prev_a] : '0;
      dtag = (prev_kind == 3) ? "R7" : prev_byp ? "R4" : (prev_t == 1) ? "R2" : "R1";
      otag = (prev_t == 1) ? "R2" : (prev_t == 2) ? "R8" : "R5";

      set_cmd(kind, VEC[j][8:1], j);
      dq_in = dlo(j);
      @(posedge clk2x); @(negedge clk2x);
      chk(otag, "dq_oe beat0", W'(dq_oe), W'(eoe));
      chk("R6", "cq beat0", W'(cq), W'(eoe));
      chk("R2", "ck high", W'(ck), W'(1));
      if (eoe) chk(dtag, "data beat0", dq_out, ew[W-1:0]);

      set_cmd(0, '0, j);
      dq_in = dhi(j);
      @(posedge clk2x); @(negedge clk2x);
      chk(otag, "dq_oe beat1", W'(dq_oe), W'(eoe));
      chk("R6", "cq beat1", W'(cq), W'(0));
      chk("R2", "ck low", W'(ck), W'(0));
      if (eoe) chk(dtag, "data beat1", dq_out, ew[2*W-1:W]);

      // R3: the write loaded in the previous row takes this row's two beats
      if (prev_t == 2) mm[prev_a] = {dhi(j), dlo(j)};
      prev_t = t; prev_a = ea; prev_byp = cur_byp; prev_kind = kind;
    end

    // R9: reset in the middle of a read
    set_cmd(1, 8'h10, 0);
    @(posedge clk2x); @(negedge clk2x);
    set_cmd(0, '0, 0);
    @(posedge clk2x); @(negedge clk2x);
    @(posedge clk2x); #1;
    rst_n = 1'b0; #1;
    chk("R9", "dq_oe in reset", W'(dq_oe), W'(0));
    chk("R9", "cq in reset", W'(cq), W'(0));
    chk("R9", "ck in reset", W'(ck), W'(0));
    @(negedge clk2x); @(negedge clk2x);
    rst_n = 1'b1;
    // R9 / R7: advance right after reset opens no burst
    set_cmd(3, '0, 0);
    @(posedge clk2x); @(negedge clk2x);
    set_cmd(0, '0, 0);
    @(posedge clk2x); @(negedge clk2x);
    @(posedge clk2x); @(negedge clk2x);
    chk("R9", "dq_oe after advance", W'(dq_oe), W'(0));
    chk("R9", "cq after advance", W'(cq), W'(0));
    @(posedge clk2x); @(negedge clk2x);
    chk("R9", "dq_oe after advance beat1", W'(dq_oe), W'(0));

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule